// File: doc/BRIEF.md
# Serial Command to SPI Bridge

The bridge takes a stream of bytes from a host link, each marked by a one-cycle valid strobe, and files them by arrival position into seven byte slots: a status image, a write slot holding the write and read interrupt bits, a read slot, two SPI control bytes, a baud byte and a data byte. A position counter steps after every accepted byte and wraps after the seventh.

When the data byte lands, the two control bytes, the baud byte and the data byte are bit-inverted and packed into a 32-bit word. That word is shifted out most significant bit first on MOSI. A generated SCLK drives a single SPI slave, and one active-low chip select frames the transfer. While a frame is pending or in flight, the bridge reports busy. Bytes that arrive during that time are dropped and tallied in a saturating overrun counter.

Top module: `cmd_spi_bridge`

## Requirements
- R1: After reset, busy is 0, cs_n is 1, sclk is 0, mosi is 0, overrun_cnt is 0 and side_regs is 0.
- R2: Accepted bytes fill the slots by arrival order: 1st status, 2nd write, 3rd read, 4th control one, 5th control two, 6th baud, 7th data. side_regs shows {status, write, read}, with status in bits 23:16.
- R3: The read slot keeps only bit 1 (bus busy) and bit 0 (abort read) of its byte. Every other bit is stored as 0.
- R4: After the 7th byte, the frame sent is ~{control one, control two, baud, data}, shifted MSB first.
- R5: MOSI changes only while SCLK is low. It is stable across every rising SCLK edge.
- R6: cs_n is low for exactly 32 rising SCLK edges per frame, and SCLK stays low whenever cs_n is high.
- R7: The SCLK period is 2 × sclk_half system clock cycles.
- R8: busy is 1 from the cycle after the 7th byte until the last bit completes. Bytes arriving while busy leave the slots and the position counter unchanged, and each one adds 1 to overrun_cnt.
- R9: overrun_cnt saturates at its all-ones value.
- R10: An sclk_half value of 0 is treated as 1, giving a 2-cycle SCLK period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte strobe |
| in_byte | input | 8 | Host byte |
| sclk_half | input | DIV_W | SCLK half period in system cycles |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | SPI serial data out |
| cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | Frame pending or shifting |
| overrun_cnt | output | OVR_W | Count of bytes dropped while busy |
| side_regs | output | 24 | Status, write and read slots |

## Verification
The bench builds the bridge with OVR_W set to 3, so the overrun counter reaches its ceiling of 7 after a handful of dropped bytes and R9 can be checked. DIV_W is set to 4, which is still wide enough for a half period of 6 and long frames that can absorb a burst of overrun bytes. The bench drives sclk_half at 2, 6 and 0, which covers the ordinary divider, the slow divider and the zero-clamp case.

// File: rtl/cmd_spi_pkg.sv
package cmd_spi_pkg;
   localparam int BYTE_W      = 8;
   localparam int NUM_SLOTS   = 7;
   localparam int SLOT_STATUS = 0;
   localparam int SLOT_WRITE  = 1;
   localparam int SLOT_READ   = 2;
   localparam int SLOT_CTRL1  = 3;
   localparam int SLOT_CTRL2  = 4;
   localparam int SLOT_BAUD   = 5;
   localparam int SLOT_DATA   = 6;
   localparam int FRAME_BYTES = 4;
   localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
   localparam int SIDE_W      = 3 * BYTE_W;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cmd_capture.sv
module cmd_capture
   import cmd_spi_pkg::*;
#(
   parameter int    OVR_W     = 8,
   parameter byte_t READ_KEEP = 8'h03
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  byte_t                       in_byte,
   input  logic                        busy,
   output logic [NUM_SLOTS*BYTE_W-1:0] slot_bus,
   output logic                        go,
   output logic [OVR_W-1:0]            ovr_cnt
);
   localparam int IDX_W = $clog2(NUM_SLOTS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_SLOTS - 1);

   logic [IDX_W-1:0] idx;
   logic             accept;

   assign accept = in_valid & ~busy;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam byte_t KEEP = (i == SLOT_READ) ? READ_KEEP : '1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_bus[i*BYTE_W +: BYTE_W] <= '0;
         else if (accept && idx == IDX_W'(i))
            slot_bus[i*BYTE_W +: BYTE_W] <= in_byte & KEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         go      <= 1'b0;
         ovr_cnt <= '0;
      end else begin
         go <= accept && (idx == IDX_LAST);
         if (accept)
            idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
         if (in_valid && busy && ovr_cnt != '1)
            ovr_cnt <= ovr_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cmd_frame_pack.sv
module cmd_frame_pack
   import cmd_spi_pkg::*;
(
   input  logic [FRAME_BYTES*BYTE_W-1:0] src,
   output logic [FRAME_W-1:0]            frame
);
   for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_pack
      assign frame[FRAME_W-1-k*BYTE_W -: BYTE_W] = ~src[k*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/spi_shift_tx.sv
module spi_shift_tx
   import cmd_spi_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [DIV_W-1:0]   half,
   output logic               sclk,
   output logic               mosi,
   output logic               cs_n,
   output logic               active
);
   localparam int BIT_W = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] sh;
   logic [DIV_W-1:0]   div;
   logic [DIV_W-1:0]   half_eff;
   logic [BIT_W-1:0]   bits;

   assign half_eff = (half == '0) ? DIV_W'(1) : half;
   assign mosi     = active & sh[FRAME_W-1];
   assign cs_n     = ~active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         div    <= '0;
         bits   <= '0;
         sclk   <= 1'b0;
         active <= 1'b0;
      end else if (load && !active) begin
         sh     <= frame;
         div    <= '0;
         bits   <= '0;
         sclk   <= 1'b0;
         active <= 1'b1;
      end else if (active) begin
         if (div >= half_eff - 1'b1) begin
            div  <= '0;
            sclk <= ~sclk;
            if (sclk) begin
               if (bits == BIT_LAST)
                  active <= 1'b0;
               else begin
                  sh   <= {sh[FRAME_W-2:0], 1'b0};
                  bits <= bits + 1'b1;
               end
            end
         end else begin
            div <= div + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cmd_spi_bridge.sv
module cmd_spi_bridge
   import cmd_spi_pkg::*;
#(
   parameter int    DIV_W     = 8,
   parameter int    OVR_W     = 8,
   parameter byte_t READ_KEEP = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic [DIV_W-1:0]  sclk_half,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n,
   output logic              busy,
   output logic [OVR_W-1:0]  overrun_cnt,
   output logic [23:0]       side_regs
);
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (OVR_W < 1) begin : g_bad_ovr
      $error("OVR_W must be at least 1");
   end
   if (SLOT_DATA - SLOT_CTRL1 + 1 != FRAME_BYTES) begin : g_bad_map
      $error("frame slots must be contiguous");
   end

   logic [NUM_SLOTS*BYTE_W-1:0] slot_bus;
   logic [FRAME_W-1:0]          frame;
   logic                        go;
   logic                        active;

   assign busy      = go | active;
   assign side_regs = {slot_bus[SLOT_STATUS*BYTE_W +: BYTE_W],
                       slot_bus[SLOT_WRITE*BYTE_W +: BYTE_W],
                       slot_bus[SLOT_READ*BYTE_W +: BYTE_W]};

   cmd_capture #(.OVR_W(OVR_W), .READ_KEEP(READ_KEEP)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .busy     (busy),
      .slot_bus (slot_bus),
      .go       (go),
      .ovr_cnt  (overrun_cnt)
   );

   cmd_frame_pack u_pack (
      .src   (slot_bus[NUM_SLOTS*BYTE_W-1 : SLOT_CTRL1*BYTE_W]),
      .frame (frame)
   );

   spi_shift_tx #(.DIV_W(DIV_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (go),
      .frame  (frame),
      .half   (sclk_half),
      .sclk   (sclk),
      .mosi   (mosi),
      .cs_n   (cs_n),
      .active (active)
   );
endmodule

// File: rtl/cmd_spi_bridge_chk.sv
module cmd_spi_bridge_chk #(
   parameter int         OVR_W     = 8,
   parameter logic [7:0] READ_KEEP = 8'h03
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sclk,
   input logic             mosi,
   input logic             cs_n,
   input logic             busy,
   input logic [OVR_W-1:0] overrun_cnt,
   input logic [23:0]      side_regs
);
   logic       sclk_q;
   logic [6:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         rises  <= '0;
      end else begin
         sclk_q <= sclk;
         if (cs_n)
            rises <= '0;
         else if (sclk && !sclk_q)
            rises <= rises + 1'b1;
      end
   end

   AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);                                                     // R6
   AST_FRAME_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> rises == 7'd32);                                     // R6
   AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $rose(sclk)) |-> $stable(mosi));                           // R5
   AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);                                                     // R8
   AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_cnt == $past(overrun_cnt)) ||
      (overrun_cnt == $past(overrun_cnt) + 1'b1));                         // R8
   AST_OVR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(overrun_cnt) == '1) |-> (overrun_cnt == '1));                 // R9
   AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (side_regs[7:0] & ~READ_KEEP) == 8'h00);                             // R3
endmodule

bind cmd_spi_bridge cmd_spi_bridge_chk #(.OVR_W(OVR_W), .READ_KEEP(READ_KEEP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk        (sclk),
   .mosi        (mosi),
   .cs_n        (cs_n),
   .busy        (busy),
   .overrun_cnt (overrun_cnt),
   .side_regs   (side_regs)
);

// File: tb/cmd_spi_bridge_bench.sv
module cmd_spi_bridge_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_W = 4;
   localparam int OVR_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_byte = '0;
   logic [DIV_W-1:0] sclk_half = 4'd2;
   logic             sclk, mosi, cs_n, busy;
   logic [OVR_W-1:0] overrun_cnt;
   logic [23:0]      side_regs;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_spi_bridge #(.DIV_W(DIV_W), .OVR_W(OVR_W)) u_cmd_spi_bridge (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .sclk_half(sclk_half), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
      .busy(busy), .overrun_cnt(overrun_cnt), .side_regs(side_regs)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_set(input logic [7:0] st, input logic [7:0] wr, input logic [7:0] rd,
                           input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] bd,
                           input logic [7:0] dt);
      send_byte(st); send_byte(wr); send_byte(rd);
      send_byte(c1); send_byte(c2); send_byte(bd); send_byte(dt);
   endtask

   task automatic grab_frame(output logic [31:0] word, output int rises, output int period);
      int t = 0, t1 = -1, t2 = -1;
      logic prev = 1'b0;
      word = '0; rises = 0;
      for (int w = 0; w < 1000 && cs_n; w++) @(negedge clk);
      while (!cs_n && t < 20000) begin
         if (sclk && !prev) begin
            word = {word[30:0], mosi};
            rises++;
            if (t1 < 0) t1 = t; else if (t2 < 0) t2 = t;
         end
         prev = sclk;
         t++;
         @(negedge clk);
      end
      period = t2 - t1;
   endtask

   task automatic test_reset();
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 cs_n", {31'd0, cs_n}, 32'd1);
      check("R1 sclk", {31'd0, sclk}, 32'd0);
      check("R1 mosi", {31'd0, mosi}, 32'd0);
      check("R1 overrun", {29'd0, overrun_cnt}, 32'd0);
      check("R1 side", {8'd0, side_regs}, 32'd0);
   endtask

   task automatic test_basic();
      logic [31:0] w; int r, p;
      sclk_half = 4'd2;
      send_set(8'hA5, 8'h3C, 8'hFF, 8'h12, 8'h34, 8'h56, 8'h78);
      check("R2 side order / R3 read mask", {8'd0, side_regs}, {8'd0, 8'hA5, 8'h3C, 8'h03});
      grab_frame(w, r, p);
      check("R4 frame", w, ~32'h12345678);
      check("R6 rise count", r, 32);
      check("R7 period", p, 4);
      check("R8 busy clear", {31'd0, busy}, 32'd0);
   endtask

   task automatic test_overrun();
      logic [31:0] w; int r, p;
      sclk_half = 4'd2;
      send_set(8'h01, 8'h80, 8'h5A, 8'hF0, 8'h0F, 8'hC3, 8'h99);
      check("R3 read mask 5A", {24'd0, side_regs[7:0]}, 32'h02);
      @(negedge clk);
      check("R8 busy during frame", {31'd0, busy}, 32'd1);
      send_byte(8'hEE); send_byte(8'hDD); send_byte(8'hCC);
      for (int w2 = 0; w2 < 1000 && !cs_n; w2++) @(negedge clk);
      check("R8 overrun count", {29'd0, overrun_cnt}, 32'd3);
      check("R8 slots untouched", {8'd0, side_regs}, {8'd0, 8'h01, 8'h80, 8'h02});
      send_set(8'h11, 8'h22, 8'h01, 8'hDE, 8'hAD, 8'hBE, 8'hEF);
      check("R8 counter not advanced", {8'd0, side_regs}, {8'd0, 8'h11, 8'h22, 8'h01});
      grab_frame(w, r, p);
      check("R8 next frame", w, ~32'hDEADBEEF);
   endtask

   task automatic test_slow_saturate();
      logic [31:0] w; int r, p;
      sclk_half = 4'd6;
      send_set(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF);
      for (int k = 0; k < 6; k++) send_byte(8'h55);
      check("R9 saturate", {29'd0, overrun_cnt}, 32'd7);
      grab_frame(w, r, p);
      check("R9 stays", {29'd0, overrun_cnt}, 32'd7);
   endtask

   task automatic test_half_zero();
      logic [31:0] w; int r, p;
      sclk_half = 4'd0;
      send_set(8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h01);
      grab_frame(w, r, p);
      check("R10 period", p, 2);
      check("R10 frame / R5 sampling", w, ~32'h80000001);
      check("R6 rise count zero half", r, 32);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_basic();
      test_overrun();
      test_slow_saturate();
      test_half_zero();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule